// File: doc/BRIEF.md
# Multi-Rail Reset Delay Controller

This block produces one active-low reset for each supervised supply rail. An external comparator reports for each rail whether the rail sits above its reset threshold. While a rail is low, its reset is held asserted. Once the rail is good, the block counts time-base ticks from a shared prescaler. It releases the reset only after the full programmed delay has elapsed. A rail that drops again, for any cause, pulls its reset back low at once and clears its count.

The delay comes from a 2-bit setting written through a strobe by the surrounding register logic. That setting survives a warm restart, where rails fall and recover without a cold-start indication. It returns to the longest delay only when `cold_start` is raised or when the block's own reset is applied. The first rail's reset also serves as the watchdog reset. A watchdog failure request is treated like a rail-1 fault, so it asserts that reset and then runs a full delay again. A status output tells the register logic that the rail-1 power-on reset is still active, so that it can refuse writes during that time.

Top module: `rail_reset_ctrl`

## Requirements
- R1: A rail whose good input is low drives its reset output low from the first clock edge after the drop, and keeps it low while the input stays low.
- R2: After a rail's good input rises, its reset stays low for exactly N ticks. It is released on the clock edge that registers the Nth tick and then stays released while the rail remains good.
- R3: The delay code maps as follows: 2'b00 gives 64 ticks, 2'b01 gives 32, 2'b10 gives 16 and 2'b11 gives 8. These are the defaults, with one tick meaning 1 ms. The applied code, visible on `cur_sel`, updates on the edge after a `cfg_we` strobe.
- R4: Block reset sets the applied code to 2'b00. A `cold_start` pulse sets it to 2'b00 on the next edge, and a write strobe in the same cycle loses to `cold_start`.
- R5: Without `cold_start`, a rail dropping and recovering leaves the applied code unchanged, and the next release uses that code.
- R6: If the rail drops while its delay is running, the count restarts from zero, and a full delay is needed after the rail returns.
- R7: A high `wd_fail` drives reset output 0 low from the next edge and restarts its delay, which runs in full once `wd_fail` is low. Resets 1 and 2 are unaffected.
- R8: Each rail's reset depends only on its own good input, apart from the shared delay code and tick.
- R9: `por1_active` is high exactly while reset output 0 is low.
- R10: Clock cycles without `tick` do not advance any delay count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| tick | input | 1 | Time-base pulse from the shared prescaler |
| rail_good | input | NUM_RAILS | Per-rail above-threshold flags from the comparators |
| wd_fail | input | 1 | Watchdog failure request for reset 0 |
| cold_start | input | 1 | Cold-start indication; restores the default delay code |
| cfg_we | input | 1 | Write strobe for the delay code |
| cfg_sel | input | 2 | Delay code to be written |
| rst_n_o | output | NUM_RAILS | Active-low reset per rail |
| por1_active | output | 1 | High while reset 0 is asserted |
| cur_sel | output | 2 | Delay code currently applied |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a configuration write and a cold-start pulse. The bench raises `cfg_we` with code 2'b11 in the same cycle as `cold_start`. It then checks that the applied code reads 2'b00 and that the next release takes 64 ticks rather than 8. The second pair is a watchdog failure and a rail fault on rail 0. The bench pulses `wd_fail` while the other rails are released, and judges that only reset 0 falls and that it comes back after exactly one full delay.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef logic [1:0] dly_code_t;

    localparam dly_code_t DLY_CODE_DEFAULT = 2'b00;

endpackage

// File: rtl/rrc_delay_cfg.sv
module rrc_delay_cfg
    import rrc_pkg::*;
#(
    parameter int DLY_UNIT = 8,
    parameter int CNT_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_start,
    input  logic             cfg_we,
    input  dly_code_t        cfg_sel,
    output dly_code_t        code,
    output logic [CNT_W-1:0] target
);

    typedef struct packed {
        dly_code_t code;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cold_start) begin
            cfg_d.code = DLY_CODE_DEFAULT;
        end else if (cfg_we) begin
            cfg_d.code = cfg_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code <= DLY_CODE_DEFAULT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign code   = cfg_q.code;
    // code 0 is the longest delay, each step halves it
    assign target = CNT_W'(DLY_UNIT) << (2'd3 - cfg_q.code);

endmodule

// File: rtl/rrc_rail_timer.sv
module rrc_rail_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fault,
    input  logic [CNT_W-1:0] target,
    output logic             released
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rel;
    } timer_state_t;

    timer_state_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (fault) begin
            tmr_d.cnt = '0;
            tmr_d.rel = 1'b0;
        end else if (!tmr_q.rel && tick) begin
            if ((tmr_q.cnt + CNT_W'(1)) >= target) begin
                tmr_d.cnt = '0;
                tmr_d.rel = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt <= '0;
            tmr_q.rel <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign released = tmr_q.rel;

endmodule

// File: rtl/rail_reset_ctrl.sv
module rail_reset_ctrl
    import rrc_pkg::*;
#(
    parameter int NUM_RAILS = 3,
    parameter int DLY_UNIT  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NUM_RAILS-1:0] rail_good,
    input  logic                 wd_fail,
    input  logic                 cold_start,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    output logic [NUM_RAILS-1:0] rst_n_o,
    output logic                 por1_active,
    output logic [1:0]           cur_sel
);

    localparam int MAX_TICKS = 8 * DLY_UNIT;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    dly_code_t              code;
    logic [CNT_W-1:0]       target;
    logic [NUM_RAILS-1:0]   fault;
    logic [NUM_RAILS-1:0]   released;

    rrc_delay_cfg #(
        .DLY_UNIT (DLY_UNIT),
        .CNT_W    (CNT_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cold_start (cold_start),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .code       (code),
        .target     (target)
    );

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        if (i == 0) begin : g_wd
            assign fault[i] = ~rail_good[i] | wd_fail;
        end else begin : g_plain
            assign fault[i] = ~rail_good[i];
        end

        rrc_rail_timer #(
            .CNT_W (CNT_W)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .fault    (fault[i]),
            .target   (target),
            .released (released[i])
        );
    end

    assign rst_n_o     = released;
    assign por1_active = ~released[0];
    assign cur_sel     = code;

endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NUM_RAILS-1:0] rail_good,
    input logic                 wd_fail,
    input logic                 cold_start,
    input logic                 cfg_we,
    input logic [1:0]           cur_sel,
    input logic [NUM_RAILS-1:0] rst_n_o
);

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_chk
        // R1: a low rail forces its reset low on the next edge
        a_r1_low_rail_resets: assert property (@(posedge clk) disable iff (!rst_n)
            !rail_good[i] |=> !rst_n_o[i]);
        // R10: no release in a cycle without a tick
        a_r10_no_tick_no_release: assert property (@(posedge clk) disable iff (!rst_n)
            (!rst_n_o[i] && !tick) |=> !rst_n_o[i]);
    end

    // R7: watchdog failure asserts reset 0
    a_r7_wd_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fail |=> !rst_n_o[0]);

    // R4: cold start restores the default code
    a_r4_cold_default: assert property (@(posedge clk) disable iff (!rst_n)
        cold_start |=> (cur_sel == 2'b00));

    // R5: the code only moves on a write or cold start
    a_r5_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !cold_start) |=> $stable(cur_sel));

endmodule

bind rail_reset_ctrl rrc_checker #(
    .NUM_RAILS (NUM_RAILS)
) u_rrc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rail_good  (rail_good),
    .wd_fail    (wd_fail),
    .cold_start (cold_start),
    .cfg_we     (cfg_we),
    .cur_sel    (cur_sel),
    .rst_n_o    (rst_n_o)
);

// File: tb/rail_reset_ctrl_bench.sv
`timescale 1ns/1ps
module rail_reset_ctrl_bench;

    localparam int NR = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic [NR-1:0] rail_good;
    logic          wd_fail;
    logic          cold_start;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [NR-1:0] rst_n_o;
    logic          por1_active;
    logic [1:0]    cur_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rail_reset_ctrl #(.NUM_RAILS(NR), .DLY_UNIT(8)) u_rail_reset_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rail_good   (rail_good),
        .wd_fail     (wd_fail),
        .cold_start  (cold_start),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .rst_n_o     (rst_n_o),
        .por1_active (por1_active),
        .cur_sel     (cur_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic int ticks_for(input logic [1:0] c);
        return 8 << (3 - c);
    endfunction

    task automatic write_code(input logic [1:0] c);
        cfg_we = 1'b1; cfg_sel = c;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    // drop rail idx one cycle, restore, check low at exp-1 and high at exp
    task automatic drop_and_time(input int idx, input int exp, input string req);
        rail_good[idx] = 1'b0;
        cyc(1);
        chk(req, rst_n_o[idx], 0);
        rail_good[idx] = 1'b1;
        cyc(exp - 1);
        chk(req, rst_n_o[idx], 0);
        cyc(1);
        chk(req, rst_n_o[idx], 1);
    endtask

    task automatic t_reset_state();
        chk("R4 reset code", cur_sel, 0);
        chk("R1 reset outputs", rst_n_o, 0);
        chk("R9 por after reset", por1_active, 1);
    endtask

    task automatic t_default_release();
        rail_good = '1;
        cyc(63);
        chk("R2 before 64", rst_n_o, 0);
        chk("R9 por during delay", por1_active, 1);
        cyc(1);
        chk("R2 at 64", rst_n_o, 3'b111);
        chk("R9 por released", por1_active, 0);
        cyc(20);
        chk("R2 stays released", rst_n_o, 3'b111);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 4; c++) begin
            write_code(2'(c));
            chk("R3 code applied", cur_sel, c);
            drop_and_time(2, ticks_for(2'(c)), "R3 delay per code");
        end
    endtask

    task automatic t_warm_keep();
        write_code(2'b11);
        drop_and_time(1, 8, "R5 warm delay");
        chk("R5 code kept", cur_sel, 3);
        chk("R8 others untouched", {rst_n_o[2], rst_n_o[0]}, 2'b11);
    endtask

    task automatic t_restart();
        write_code(2'b10);
        rail_good[0] = 1'b0;
        cyc(1);
        rail_good[0] = 1'b1;
        cyc(10);
        chk("R6 mid delay", rst_n_o[0], 0);
        drop_and_time(0, 16, "R6 full restart");
    endtask

    task automatic t_watchdog();
        write_code(2'b11);
        wd_fail = 1'b1;
        cyc(1);
        chk("R7 reset0 low", rst_n_o[0], 0);
        chk("R9 por on wd", por1_active, 1);
        chk("R7 others high", rst_n_o[2:1], 2'b11);
        wd_fail = 1'b0;
        cyc(7);
        chk("R7 before delay", rst_n_o[0], 0);
        cyc(1);
        chk("R7 after delay", rst_n_o[0], 1);
    endtask

    task automatic t_no_tick();
        tick = 1'b0;
        rail_good[2] = 1'b0;
        cyc(1);
        rail_good[2] = 1'b1;
        cyc(100);
        chk("R10 no tick hold", rst_n_o[2], 0);
        tick = 1'b1;
        cyc(7);
        chk("R10 resumes low", rst_n_o[2], 0);
        cyc(1);
        chk("R10 resumes release", rst_n_o[2], 1);
    endtask

    task automatic t_cold();
        write_code(2'b01);
        cold_start = 1'b1;
        cyc(1);
        cold_start = 1'b0;
        chk("R4 cold alone", cur_sel, 0);
        write_code(2'b10);
        cold_start = 1'b1; cfg_we = 1'b1; cfg_sel = 2'b11;
        cyc(1);
        cold_start = 1'b0; cfg_we = 1'b0;
        chk("R4 cold beats write", cur_sel, 0);
        drop_and_time(1, 64, "R4 default delay after cold");
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b1; rail_good = '0; wd_fail = 1'b0;
        cold_start = 1'b0; cfg_we = 1'b0; cfg_sel = 2'b00;
        cyc(3);
        t_reset_state();
        rst_n = 1'b1;
        cyc(2);
        t_reset_state();
        t_default_release();
        t_codes();
        t_warm_keep();
        t_restart();
        t_watchdog();
        t_no_tick();
        t_cold();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 100000 && !done; k++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule